// File: doc/BRIEF.md
# Resynchronizing Asynchronous Serial Receiver

This block converts an asynchronous serial line into parallel characters. It runs on a system clock and advances only on a one-cycle enable pulse that comes sixteen times per bit period. The line is idle high. A character is a low start bit, then 5 to 9 data bits sent least significant bit first, then an optional parity bit, then one or two high stop bits. The frame format is set through static configuration inputs.

The line first passes through a two-flop synchronizer. A filter then accepts a new line level only after it has held for half a bit time. A filtered falling edge while idle starts a character. Each filtered transition inside a character moves the bit-phase counter to that edge, so the receiver keeps its alignment when the sender's rate is off by a few percent. Each completed character goes into a holding register with its own error flags. A host read strobe releases the register.

Top module: `serial_rx_resync`

## Requirements
- R1: After reset, `dvalid`, `err_frame`, `err_par`, `err_break` and `overrun` are 0.
- R2: With `cfg_len` set to N (5 to 9), a frame delivers its N data bits, received least significant bit first, right-justified on `dout`; `dout` bits above N are 0 and `dvalid` rises to 1.
- R3: A low pulse on `rx` shorter than half a bit time (fewer than 8 enable pulses) is ignored: no character is produced.
- R4: Every filtered transition inside a character re-aligns the bit phase. A character of alternating bits (0x55, 8 data bits) is decoded correctly when the sender's bit period is 14 or 18 enable pulses instead of 16.
- R5: When `cfg_par_en` is 1 and N < 9, one parity bit follows the last data bit. With `cfg_par_odd`=0 the data bits plus the parity bit must hold an even number of ones; with 1, an odd number. A mismatch sets `err_par` with the character.
- R6: When N = 9, `cfg_par_en` has no effect: no parity bit is expected and `err_par` stays 0.
- R7: `cfg_two_stop`=1 selects two stop bits. If either stop bit is sampled low, `err_frame` is set with the character.
- R8: If the line stays low from the start bit through the last stop bit, the block delivers an all-zero character with both `err_frame` and `err_break` set. It delivers exactly one character until the line has returned high.
- R9: If a character completes while `dvalid` is 1 and `rd` is not asserted, the character is discarded, `dout` keeps the unread character, and `overrun` is set.
- R10: A one-cycle `rd` pulse clears `dvalid`, `err_frame`, `err_par`, `err_break` and `overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Enable pulse, 16 per bit period |
| rx | input | 1 | Asynchronous serial line, idle high |
| cfg_len | input | 4 | Data bits per character, 5 to 9 |
| cfg_par_en | input | 1 | Parity bit present (ignored when 9 data bits) |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_two_stop | input | 1 | 1 = two stop bits, 0 = one |
| rd | input | 1 | Host read strobe, clears valid and flags |
| dout | output | 9 | Received character, right-justified |
| dvalid | output | 1 | Holding register contains an unread character |
| err_frame | output | 1 | A stop bit was sampled low |
| err_par | output | 1 | Parity mismatch |
| err_break | output | 1 | Line was low for the whole character |
| overrun | output | 1 | A character was lost because the previous one was unread |

## Verification
Characters are sent with 5, 8 and 9 data bits. The 5-bit and 9-bit cases expose an error in bit order or in right-justification that an 8-bit frame would hide. The parity cases use one matching and one wrong parity bit under even parity, plus a matching bit under odd parity, to separate a wrong sense from a missing check. Alternating-bit frames at bit periods of 14 and 18 enable pulses drift off the bit centre within a few bits unless the phase re-aligns on data edges, so they show whether re-alignment happens. A short low glitch, a held-low line, a low second stop bit and two unread characters in a row cover the filter, the break, the framing and the overrun paths.

// File: rtl/serial_rx_resync.sv
module serial_rx_resync #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rx,
  input  logic [3:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       cfg_two_stop,
  input  logic       rd,
  output logic [8:0] dout,
  output logic       dvalid,
  output logic       err_frame,
  output logic       err_par,
  output logic       err_break,
  output logic       overrun
);
  localparam int CW   = $clog2(OVS);
  localparam int HALF = OVS / 2;
  localparam int FW   = $clog2(HALF);

  logic [1:0]    sy;
  logic          flt;
  logic [FW-1:0] fc;
  logic          busy, px, perr, ferr, zall;
  logic [CW-1:0] cnt;
  logic [3:0]    idx;
  logic [8:0]    sh;

  wire rx_s    = sy[1];
  wire mis     = rx_s != flt;
  wire edge_ok = tick && mis && (fc == FW'(HALF - 1));
  wire start   = !busy && edge_ok && !rx_s;

  wire [3:0] nb   = (cfg_len < 4'd5) ? 4'd5 : (cfg_len > 4'd9) ? 4'd9 : cfg_len;
  wire       pe   = cfg_par_en && (nb != 4'd9);
  wire [3:0] last = nb + {3'b0, pe} + {3'b0, cfg_two_stop};
  wire       samp = busy && tick && (edge_ok ? cnt[CW-1] : (cnt == CW'(OVS - 1)));
  wire       fin  = samp && (idx == last);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sy <= 2'b11;
    else        sy <= {sy[0], rx};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flt <= 1'b1;
      fc  <= '0;
    end else if (tick) begin
      if (!mis) fc <= '0;
      else if (fc == FW'(HALF - 1)) begin
        fc  <= '0;
        flt <= rx_s;
      end else fc <= fc + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0; cnt <= '0; idx <= '0; sh <= '0;
      px <= 1'b0; perr <= 1'b0; ferr <= 1'b0; zall <= 1'b1;
      dout <= '0; dvalid <= 1'b0;
      err_frame <= 1'b0; err_par <= 1'b0; err_break <= 1'b0; overrun <= 1'b0;
    end else begin
      if (rd) begin
        dvalid <= 1'b0; err_frame <= 1'b0; err_par <= 1'b0;
        err_break <= 1'b0; overrun <= 1'b0;
      end
      if (start) begin
        busy <= 1'b1; cnt <= '0; idx <= '0;
        px <= 1'b0; perr <= 1'b0; ferr <= 1'b0; zall <= 1'b1;
      end else if (busy && tick) begin
        cnt <= (edge_ok || cnt == CW'(OVS - 1)) ? '0 : cnt + 1'b1;
        if (samp) begin
          zall <= zall & ~rx_s;
          if (idx < nb) begin
            sh <= {rx_s, sh[8:1]};
            px <= px ^ rx_s;
          end else if (pe && idx == nb) perr <= px ^ rx_s ^ cfg_par_odd;
          else if (!rx_s) ferr <= 1'b1;
          if (idx == last) begin
            busy <= 1'b0;
            if (dvalid && !rd) overrun <= 1'b1;
            else begin
              dout      <= sh >> (4'd9 - nb);
              dvalid    <= 1'b1;
              err_frame <= ferr | ~rx_s;
              err_par   <= perr;
              err_break <= zall & ~rx_s;
            end
          end else idx <= idx + 1'b1;
        end
      end
    end

  assert_start_on_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !flt);
  assert_nine_no_parity_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && nb == 4'd9 && (!dvalid || rd)) |=> !err_par);
  assert_break_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_break |-> (err_frame && dout == 9'd0));
  assert_overrun_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && dvalid && !rd) |=> (overrun && $stable(dout)));
  assert_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !fin) |=> (!dvalid && !overrun && !err_frame));
endmodule

// File: tb/sim_serial_rx_resync.sv
module sim_serial_rx_resync;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV = 2;

  logic clk = 0, rst_n = 0, tick = 0, rx = 1, rd = 0;
  logic [3:0] cfg_len = 4'd8;
  logic cfg_par_en = 0, cfg_par_odd = 0, cfg_two_stop = 0;
  logic [8:0] dout;
  logic dvalid, err_frame, err_par, err_break, overrun;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  serial_rx_resync u0 (.clk, .rst_n, .tick, .rx, .cfg_len, .cfg_par_en,
    .cfg_par_odd, .cfg_two_stop, .rd, .dout, .dvalid, .err_frame, .err_par,
    .err_break, .overrun);

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) tick <= ~tick;

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bit_out(input bit v, input int tpb);
    rx = v;
    repeat (tpb * TDIV) @(negedge clk);
  endtask

  task automatic send(input [8:0] d, input int nb, input bit hp, input bit pv,
                      input bit s1, input bit two, input bit s2, input int tpb);
    bit_out(1'b0, tpb);
    for (int i = 0; i < nb; i++) bit_out(d[i], tpb);
    if (hp) bit_out(pv, tpb);
    bit_out(s1, tpb);
    if (two) bit_out(s2, tpb);
    bit_out(1'b1, 48);
  endtask

  task automatic rd_pulse();
    rd = 1; @(negedge clk); rd = 0; @(negedge clk);
  endtask

  function automatic bit par(input [8:0] d, input int nb);
    bit p = 0;
    for (int i = 0; i < nb; i++) p ^= d[i];
    return p;
  endfunction

  task automatic cfg(input int len, input bit pen, input bit podd, input bit two);
    cfg_len = 4'(len); cfg_par_en = pen; cfg_par_odd = podd; cfg_two_stop = two;
  endtask

  task automatic t_reset();
    chk("R1 dvalid", dvalid, 0);
    chk("R1 flags", {err_frame, err_par, err_break, overrun}, 0);
  endtask

  task automatic t_len();
    cfg(8, 0, 0, 0); rd_pulse();
    send(9'h0A7, 8, 0, 0, 1, 0, 0, 16);
    chk("R2 8-bit data", dout, 9'h0A7);
    chk("R2 8-bit valid", dvalid, 1);
    chk("R2 8-bit no error", {err_frame, err_par, err_break}, 0);
    cfg(5, 0, 0, 0); rd_pulse();
    send(9'h1F6, 5, 0, 0, 1, 0, 0, 16);
    chk("R2 5-bit right-justified", dout, 9'h016);
    chk("R10 read then new char valid", dvalid, 1);
  endtask

  task automatic t_glitch();
    cfg(8, 0, 0, 0); rd_pulse();
    chk("R10 rd clears valid", dvalid, 0);
    rx = 0; repeat (6 * TDIV) @(negedge clk); rx = 1;
    repeat (40 * 16 * TDIV) @(negedge clk);
    chk("R3 glitch ignored", dvalid, 0);
  endtask

  task automatic t_rate();
    cfg(8, 0, 0, 0); rd_pulse();
    send(9'h055, 8, 0, 0, 1, 0, 0, 18);
    chk("R4 slow sender data", dout, 9'h055);
    chk("R4 slow sender frame", err_frame, 0);
    rd_pulse();
    send(9'h055, 8, 0, 0, 1, 0, 0, 14);
    chk("R4 fast sender data", dout, 9'h055);
    chk("R4 fast sender valid", dvalid, 1);
  endtask

  task automatic t_parity();
    cfg(8, 1, 0, 0); rd_pulse();
    send(9'h03C, 8, 1, par(9'h03C, 8), 1, 0, 0, 16);
    chk("R5 even good data", dout, 9'h03C);
    chk("R5 even good parity", err_par, 0);
    rd_pulse();
    send(9'h03C, 8, 1, ~par(9'h03C, 8), 1, 0, 0, 16);
    chk("R5 even bad parity", err_par, 1);
    cfg(8, 1, 1, 0); rd_pulse();
    send(9'h007, 8, 1, ~par(9'h007, 8), 1, 0, 0, 16);
    chk("R5 odd good parity", err_par, 0);
    chk("R5 odd data", dout, 9'h007);
  endtask

  task automatic t_nine();
    cfg(9, 1, 0, 0); rd_pulse();
    send(9'h1A5, 9, 0, 0, 1, 0, 0, 16);
    chk("R6 9-bit data", dout, 9'h1A5);
    chk("R6 9-bit no parity error", err_par, 0);
    chk("R6 9-bit no framing error", err_frame, 0);
  endtask

  task automatic t_stop();
    cfg(8, 0, 0, 1); rd_pulse();
    send(9'h081, 8, 0, 0, 1, 1, 0, 16);
    chk("R7 low second stop", err_frame, 1);
    chk("R7 data kept", dout, 9'h081);
    rd_pulse();
    chk("R10 rd clears frame error", err_frame, 0);
    send(9'h081, 8, 0, 0, 1, 1, 1, 16);
    chk("R7 good two stops", err_frame, 0);
  endtask

  task automatic t_break();
    cfg(8, 0, 0, 0); rd_pulse();
    rx = 0; repeat (24 * 16 * TDIV) @(negedge clk);
    rx = 1; repeat (3 * 16 * TDIV) @(negedge clk);
    chk("R8 break valid", dvalid, 1);
    chk("R8 break data", dout, 0);
    chk("R8 break flags", {err_frame, err_break}, 2'b11);
    chk("R8 single char", overrun, 0);
  endtask

  task automatic t_overrun();
    cfg(8, 0, 0, 0); rd_pulse();
    send(9'h011, 8, 0, 0, 1, 0, 0, 16);
    send(9'h0EE, 8, 0, 0, 1, 0, 0, 16);
    chk("R9 overrun set", overrun, 1);
    chk("R9 first char kept", dout, 9'h011);
    rd_pulse();
    chk("R10 rd clears overrun", {dvalid, overrun}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_len();
    t_glitch();
    t_rate();
    t_parity();
    t_nine();
    t_stop();
    t_break();
    t_overrun();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule